// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block is the central arbiter of a shared 32-bit message bus that several masters use. Each master has its own active-low request and its own active-low grant. A master that has a frame-data message to move also pulls its high-priority request low. The arbiter combines these into one shared, active-low high-priority line. While that line is low, only masters that are asserting high priority can win. Command traffic is served only when no master asserts high priority. Within each level, grants go round-robin, and each level keeps its own record of the last index it served.

A granted master becomes the initiator. It frames its message with a shared active-low envelope. The grant stays in place until that envelope ends, even if the master drops its request during the message. One idle clock follows before the next grant. Apart from this, the arbiter keeps a count of active frame-forwarding reservations, which are added and dropped by pulses. It drives an active-low overload line whenever the count reaches a programmable limit.

Top module: `prioBusArbiter`

## Requirements
- R1: During and right after reset, every grant is high (none given), the reservation count is zero, and no high-priority indication is driven.
- R2: At most one grant line is low in any cycle.
- R3: A grant is issued only at a clock edge where that master's request was sampled low, and only while no message is in progress. It becomes visible one clock after the request is sampled. With no request pending, no grant is given.
- R4: If any master has both its request and its high-priority request low at the arbitration edge, the grant goes to one of those masters.
- R5: The shared high-priority line is low exactly when at least one master has both its request and its high-priority request low. A high-priority request without a request is ignored.
- R6: Among high-priority candidates, the winner is the first index above the last high-priority winner, wrapping from N-1 to 0. After reset, the search starts at index 0.
- R7: Among ordinary candidates, the winner is the first index above the last ordinary winner, wrapping from N-1 to 0. This pointer is independent of high-priority grants, and after reset the search starts at index 0.
- R8: Once given, a grant stays low while the envelope has not yet started and while it is low. This holds even if the master's request goes high.
- R9: The grant is released at the first edge that samples the envelope high after it was low. No grant is driven at the following edge, so the next grant appears two edges after the envelope end is sampled.
- R10: A reservation-add pulse raises the count by one and a drop pulse lowers it by one. Both in the same cycle leave it unchanged. The count saturates at 2^CW-1 and at zero.
- R11: Overload is low exactly when the reservation count is greater than or equal to the limit input. A limit of zero therefore gives overload at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqN | input | N | Per-master request, active low |
| hiReqN | input | N | Per-master high-priority request, active low, valid with reqN |
| envN | input | 1 | Shared message envelope driven by the initiator, active low |
| rsvAdd | input | 1 | Add one forwarding reservation |
| rsvDrop | input | 1 | Drop one forwarding reservation |
| rsvLimit | input | CW | Reservation count at which overload asserts |
| gntN | output | N | Per-master grant, active low |
| busHpN | output | 1 | Shared high-priority line, active low |
| ovldN | output | 1 | Forwarding overload, active low |

## Verification
The scoreboard predicts every winner from two separate round-robin pointers. It interleaves high and ordinary traffic, so an arbiter that shared one pointer, or that restarted its search at index 0, would grant the wrong master. One master asserts high priority without requesting: a design that honoured the stray bit would drive the shared line and give the grant to a master that did not request. Another master drops its request in the middle of a message, where an arbiter that did not hold the grant for the whole envelope would release it early. The gap after each envelope is sampled, so a grant issued one clock too soon is caught. The reservation counter is driven past its maximum, below zero, and with simultaneous add and drop, and the limit is set to zero. Wrapping or an off-by-one comparison would then show up on the overload line.

// File: rtl/prioBusArbPkg.sv
package prioBusArbPkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_BUSY  = 2'd2,
    ARB_GAP   = 2'd3
  } arbState_t;

  typedef struct packed {
    logic load;
    logic clear;
    logic useHi;
  } arbStrobe_t;
endpackage

// File: rtl/prioRrPick.sv
module prioRrPick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    // search downward so the smallest distance above last wins
    for (int k = N; k >= 1; k--) begin
      int j;
      j = int'(last) + k;
      if (j >= N) j = j - N;
      if (mask[j]) begin
        valid = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/prioBusArbCtrl.sv
module prioBusArbCtrl
  import prioBusArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyHi,
  input  logic       anyLo,
  input  logic       envN,
  output arbStrobe_t strobe
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ARB_IDLE: begin
        if (anyHi || anyLo) begin
          strobe.load  = 1'b1;
          strobe.useHi = anyHi;
          stateNext    = ARB_GRANT;
        end
      end
      ARB_GRANT: begin
        if (!envN) stateNext = ARB_BUSY;
      end
      ARB_BUSY: begin
        if (envN) begin
          strobe.clear = 1'b1;
          stateNext    = ARB_GAP;
        end
      end
      ARB_GAP: stateNext = ARB_IDLE;
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/prioBusArbData.sv
module prioBusArbData
  import prioBusArbPkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  reqN,
  input  logic [N-1:0]  hiReqN,
  input  logic          rsvAdd,
  input  logic          rsvDrop,
  input  logic [CW-1:0] rsvLimit,
  input  arbStrobe_t    strobe,
  output logic          anyHi,
  output logic          anyLo,
  output logic [N-1:0]  gntN,
  output logic          busHpN,
  output logic          ovldN
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] PTR_INIT = IW'(N - 1);
  localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};

  logic [N-1:0]  hiMask, loMask, gntReg;
  logic [IW-1:0] lastHi, lastLo, hiIdx, loIdx, winIdx;
  logic [CW-1:0] rsvCnt;

  assign loMask = ~reqN;
  assign hiMask = ~reqN & ~hiReqN;

  prioRrPick #(.N(N), .IW(IW)) hiPick_i (
    .mask(hiMask), .last(lastHi), .valid(anyHi), .idx(hiIdx)
  );
  prioRrPick #(.N(N), .IW(IW)) loPick_i (
    .mask(loMask), .last(lastLo), .valid(anyLo), .idx(loIdx)
  );

  assign winIdx = strobe.useHi ? hiIdx : loIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntReg <= '0;
      lastHi <= PTR_INIT;
      lastLo <= PTR_INIT;
    end else if (strobe.load) begin
      gntReg         <= '0;
      gntReg[winIdx] <= 1'b1;
      if (strobe.useHi) lastHi <= winIdx;
      else              lastLo <= winIdx;
    end else if (strobe.clear) begin
      gntReg <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsvCnt <= '0;
    end else if (rsvAdd && !rsvDrop && rsvCnt != CNT_MAX) begin
      rsvCnt <= rsvCnt + 1'b1;
    end else if (rsvDrop && !rsvAdd && rsvCnt != '0) begin
      rsvCnt <= rsvCnt - 1'b1;
    end
  end

  assign gntN   = ~gntReg;
  assign busHpN = ~anyHi;
  assign ovldN  = ~(rsvCnt >= rsvLimit);
endmodule

// File: rtl/prioBusArbiter.sv
module prioBusArbiter
  import prioBusArbPkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  reqN,
  input  logic [N-1:0]  hiReqN,
  input  logic          envN,
  input  logic          rsvAdd,
  input  logic          rsvDrop,
  input  logic [CW-1:0] rsvLimit,
  output logic [N-1:0]  gntN,
  output logic          busHpN,
  output logic          ovldN
);
  arbStrobe_t strobe;
  logic       anyHi, anyLo;

  prioBusArbCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .anyHi(anyHi), .anyLo(anyLo),
    .envN(envN), .strobe(strobe)
  );

  prioBusArbData #(.N(N), .CW(CW)) data_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .hiReqN(hiReqN),
    .rsvAdd(rsvAdd), .rsvDrop(rsvDrop), .rsvLimit(rsvLimit),
    .strobe(strobe), .anyHi(anyHi), .anyLo(anyLo),
    .gntN(gntN), .busHpN(busHpN), .ovldN(ovldN)
  );
endmodule

// File: rtl/prioBusArbiterChk.sv
module prioBusArbiterChk #(
  parameter int N  = 4,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  reqN,
  input logic [N-1:0]  hiReqN,
  input logic          envN,
  input logic          rsvAdd,
  input logic          rsvDrop,
  input logic [CW-1:0] rsvLimit,
  input logic [N-1:0]  gntN,
  input logic          ovldN
);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN));

  p_grant_requested_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~gntN) != '0 && $past(gntN) == '1) |-> (($past(~reqN) & ~gntN) != '0));

  p_high_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((~gntN) != '0 && $past(gntN) == '1 && $past(~reqN & ~hiReqN) != '0)
      |-> (($past(~reqN & ~hiReqN) & ~gntN) != '0));

  p_hold_in_msg_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((~gntN) != '0 && !envN) |=> (gntN == $past(gntN)));

  p_idle_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&gntN) |=> (&gntN));

  p_ovld_steady_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rsvAdd && !rsvDrop) |=> (($past(rsvLimit) != rsvLimit) || (ovldN == $past(ovldN))));
endmodule

bind prioBusArbiter prioBusArbiterChk #(.N(N), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .reqN(reqN), .hiReqN(hiReqN), .envN(envN),
  .rsvAdd(rsvAdd), .rsvDrop(rsvDrop), .rsvLimit(rsvLimit),
  .gntN(gntN), .ovldN(ovldN)
);

// File: tb/prioBusArbiter_tb_top.sv
module prioBusArbiter_tb_top;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  reqN, hiReqN, gntN;
  logic          envN, rsvAdd, rsvDrop, busHpN, ovldN;
  logic [CW-1:0] rsvLimit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int expQ[$];

  always #4 clk = ~clk;

  prioBusArbiter #(.N(N), .CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .hiReqN(hiReqN), .envN(envN),
    .rsvAdd(rsvAdd), .rsvDrop(rsvDrop), .rsvLimit(rsvLimit),
    .gntN(gntN), .busHpN(busHpN), .ovldN(ovldN)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one predicted winner per new grant
  logic [N-1:0] prevGnt = '1;
  always @(negedge clk) begin
    if (rstN && prevGnt == '1 && gntN != '1) begin
      int got;
      got = -1;
      for (int i = 0; i < N; i++) if (!gntN[i]) got = i;
      if (expQ.size() == 0) chk("R3 unexpected grant", got, 32'hFFFF_FFFF);
      else                  chk("R6/R7 winner index", got, expQ.pop_front());
    end
    prevGnt = gntN;
  end

  task automatic serve(int exp, bit dropReq);
    int waitN;
    logic [N-1:0] savedReq;
    expQ.push_back(exp);
    waitN = 0;
    while (gntN == '1 && waitN < 12) begin
      @(negedge clk);
      waitN++;
    end
    chk("R3 grant issued", 32'(gntN != '1), 1);
    savedReq = reqN;
    @(negedge clk);
    envN = 1'b0;
    if (dropReq) reqN[exp] = 1'b1;
    repeat (2) begin
      @(negedge clk);
      if (dropReq) chk("R8 grant held", 32'(gntN[exp]), 0);
    end
    envN = 1'b1;
    @(negedge clk);
    chk("R9 released at envelope end", 32'(gntN), 32'hF);
    @(negedge clk);
    chk("R9 idle gap", 32'(gntN), 32'hF);
    reqN = savedReq;
  endtask

  task automatic rsvPulse(bit a, bit d, bit expOvldN, string tag);
    rsvAdd  = a;
    rsvDrop = d;
    @(negedge clk);
    rsvAdd  = 1'b0;
    rsvDrop = 1'b0;
    chk(tag, 32'(ovldN), 32'(expOvldN));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqN = '1; hiReqN = '1; envN = 1'b1;
    rsvAdd = 1'b0; rsvDrop = 1'b0; rsvLimit = 4'd3;
    repeat (3) @(negedge clk);
    chk("R1 no grant in reset", 32'(gntN), 32'hF);
    chk("R1 no overload in reset", 32'(ovldN), 1);
    chk("R1 no high line in reset", 32'(busHpN), 1);
    rstN = 1'b1;
    @(negedge clk);

    // ordinary round robin from index 0
    reqN = 4'b0000;
    serve(0, 0); serve(1, 0); serve(2, 0); serve(3, 0); serve(0, 0);

    // high priority on masters 1 and 3
    hiReqN = 4'b0101;
    #1 chk("R5 high line asserted", 32'(busHpN), 0);
    serve(1, 0); serve(3, 0); serve(1, 0);

    // R7: ordinary pointer continues after 0
    hiReqN = 4'b1111;
    serve(1, 0);
    serve(2, 1);
    serve(3, 0);

    // R5: stray high bit from non-requester 2 is ignored
    reqN = 4'b0100; hiReqN = 4'b1011;
    #1 chk("R5 stray high ignored", 32'(busHpN), 1);
    serve(0, 0);

    // R6: high pointer continues after 1
    reqN = 4'b0000; hiReqN = 4'b1010;
    serve(2, 0); serve(0, 0);

    // R3: no requests, no grant
    reqN = '1; hiReqN = '1;
    repeat (4) @(negedge clk);
    chk("R3 idle without request", 32'(gntN), 32'hF);

    // reservations, limit 3
    rsvPulse(1, 0, 1, "R10 count 1");
    rsvPulse(1, 0, 1, "R10 count 2");
    rsvPulse(1, 0, 0, "R11 count 3 reaches limit");
    rsvPulse(1, 1, 0, "R10 add+drop no change");
    rsvPulse(0, 1, 1, "R11 below limit releases");
    rsvPulse(0, 1, 1, "R10 count 1");
    rsvPulse(0, 1, 1, "R10 count 0");
    rsvPulse(0, 1, 1, "R10 floor at zero");
    rsvLimit = 4'd1;
    rsvPulse(1, 0, 0, "R10 floor kept, count 1 hits limit 1");
    rsvPulse(0, 1, 1, "R11 back to zero");
    rsvLimit = 4'd0;
    #1 chk("R11 zero limit overloads", 32'(ovldN), 0);
    rsvLimit = 4'd15;
    for (int i = 0; i < 16; i++) begin
      rsvAdd = 1'b1;
      @(negedge clk);
    end
    rsvAdd = 1'b0;
    chk("R10 saturates at max", 32'(ovldN), 0);
    rsvPulse(0, 1, 1, "R10 one below max");

    @(negedge clk);
    chk("R6/R7 all predictions consumed", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule